// File: doc/BRIEF.md
# Per-Channel Energy Accumulator with Zero-Crossing Windows

This block integrates signed power samples into energy registers. It has six current channels, split into two groups of three, and keeps one active-energy register and one reactive-energy register for each channel. Power values arrive together under a single sample strobe. A host reads any register through a simple one-cycle read port.

Each kind of energy (active or reactive) runs in one of two styles:
- **Free-running:** the register integrates continuously. An optional read-with-reset empties a register in the same cycle that it is read.
- **Line-cycle:** an externally supplied half-cycle zero-crossing strobe is counted. After a programmed number of crossings, the running sum is frozen into a readable copy and integration starts again from zero.

The block also reports the direction of power for a selectable group of three channels, separately for active and reactive power, and pulses an event when a channel's direction flips.

Configuration is a single 32-bit word written through `cfg_we`/`cfg_wdata`. It takes effect on the cycle after the write.

Top module: `eacc_top`

## Requirements
- R1: On every cycle with `smp_valid` high, each channel's active and reactive samples (signed, two's complement) are added to that channel's registers. `rd_addr` bit AW-1 selects the kind (0 = active, 1 = reactive) and the low bits select the channel. `rd_data` in the cycle after `rd_en` shows the register as it stood before that cycle's sample. In any cycle not preceded by `rd_en`, `rd_data` is zero.
- R2: The mode fields at config bits [7:6] (active) and [9:8] (reactive) are not decoded. Every code, reserved ones included, gives the same signed accumulation as code 00.
- R3: After reset, all energy, latched values, flags, pulses and `rd_data` are zero. The config word resets to 0x00000008, which has read-with-reset (bit 3) set.
- R4: In free-running mode with bit 3 set, a read clears the addressed register atomically. A sample arriving in the same cycle becomes the register's new content, so no energy is lost.
- R5: With bit 3 clear, reads leave every register unchanged.
- R6: A kind in line-cycle mode (bit 0 for active, bit 1 for reactive) returns its latched value on reads, and read-with-reset has no effect on it.
- R7: Bit 2 enables counting of zero-crossing strobes whenever at least one line-cycle bit is set. Bits [31:16] give the window length, with 0 treated as 1. On the crossing that completes the window:
  - every line-cycle kind latches its sum including any same-cycle sample;
  - that kind restarts its sum from zero;
  - that kind raises its own done flag for exactly the next cycle.
- R8: A register wraps modulo 2^EW on overflow. The per-channel overflow flag for that kind then sets and stays set until reset.
- R9: Config bit 4 (active) and bit 5 (reactive) pick the monitored group: 0 = channels 0..2, 1 = channels 3..5. Output bit i is the sign (1 = negative) of the latest sample of channel group*3+i. The outputs update the cycle after a valid sample and hold otherwise.
- R10: Flip bit i pulses for one cycle when the new sample of the monitored channel has a different sign from the previous sample of that same channel. A sign history is kept for all six channels.
- R11: A read of a channel index at or above six returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the configuration word |
| cfg_wdata | input | 32 | Configuration word |
| smp_valid | input | 1 | Power samples valid this cycle |
| p_act | input | 2*GRP*PW | Active power samples, channel c at [c*PW +: PW] |
| p_rea | input | 2*GRP*PW | Reactive power samples, same packing |
| zx_strobe | input | 1 | Voltage zero-crossing strobe |
| rd_en | input | 1 | Host read request |
| rd_addr | input | clog2(2*GRP)+1 | Kind bit and channel index |
| rd_data | output | EW | Read result, one cycle after the request |
| act_neg | output | GRP | Active-power sign of the monitored group |
| act_flip | output | GRP | Active-power sign-change pulses |
| rea_neg | output | GRP | Reactive-power sign of the monitored group |
| rea_flip | output | GRP | Reactive-power sign-change pulses |
| lc_done_act | output | 1 | Active line-cycle window completed |
| lc_done_rea | output | 1 | Reactive line-cycle window completed |
| ovf_act | output | 2*GRP | Sticky active overflow per channel |
| ovf_rea | output | 2*GRP | Sticky reactive overflow per channel |

## Verification
The properties are checked on every cycle:
- an idle read port returns zero;
- done flags appear only right after a crossing strobe;
- overflow flags never drop;
- sign outputs move only after a valid sample, and flip pulses appear only then.

The arithmetic content of the registers can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These contents are:
- atomic clear with a same-cycle sample;
- the latched window sums and the restart from zero;
- the treatment of a zero window length;
- reserved mode codes;
- wrap values;
- group switching.

// File: rtl/eacc_pkg.sv
package eacc_pkg;

    localparam int LC_CNT_W = 16;

    typedef struct packed {
        logic [LC_CNT_W-1:0] lc_cycles;
        logic [5:0]          spare;
        logic [1:0]          rea_mode;
        logic [1:0]          act_mode;
        logic                rea_grp;
        logic                act_grp;
        logic                rd_clr;
        logic                zx_sel;
        logic                lc_rea;
        logic                lc_act;
    } eacc_cfg_t;

    localparam logic [31:0] CFG_RESET = 32'h0000_0008;

    typedef enum logic {
        KIND_ACT = 1'b0,
        KIND_REA = 1'b1
    } eacc_kind_e;

endpackage

// File: rtl/eacc_lane.sv
module eacc_lane #(
    parameter int EW = 32,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_vld,
    input  logic [PW-1:0] sample,
    input  logic          lc_mode,
    input  logic          win_end,
    input  logic          rd_clear,
    output logic [EW-1:0] rd_val,
    output logic          ovf
);

    typedef struct packed {
        logic [EW-1:0] acc;
        logic [EW-1:0] hold;
        logic          ovf;
    } lane_st_t;

    lane_st_t      st_d, st_q;
    logic [EW-1:0] addend;
    logic [EW-1:0] sum;
    logic          wrap_hit;

    always_comb begin
        st_d     = st_q;
        addend   = sample_vld ? {{(EW-PW){sample[PW-1]}}, sample} : '0;
        sum      = st_q.acc + addend;
        // signed overflow: operands agree in sign, result does not
        wrap_hit = sample_vld && !rd_clear
                   && (st_q.acc[EW-1] == addend[EW-1])
                   && (sum[EW-1] != st_q.acc[EW-1]);
        if (lc_mode && win_end) begin
            st_d.hold = sum;
            st_d.acc  = '0;
        end else if (rd_clear) begin
            st_d.acc  = addend;
        end else begin
            st_d.acc  = sum;
        end
        st_d.ovf = st_q.ovf | wrap_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_val = lc_mode ? st_q.hold : st_q.acc;
    assign ovf    = st_q.ovf;

endmodule

// File: rtl/eacc_zx_window.sv
module eacc_zx_window #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_en,
    input  logic          zx,
    input  logic [CW-1:0] target,
    output logic          win_end
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   next_cnt;
    logic [CW:0]   limit;

    always_comb begin
        limit    = (target == '0) ? (CW+1)'(1) : {1'b0, target};
        next_cnt = {1'b0, cnt_q} + (CW+1)'(1);
        win_end  = count_en && zx && (next_cnt >= limit);
        cnt_d    = cnt_q;
        if (!count_en) begin
            cnt_d = '0;
        end else if (zx) begin
            cnt_d = win_end ? '0 : next_cnt[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/eacc_sign_mon.sv
module eacc_sign_mon #(
    parameter int GRP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic [2*GRP-1:0] msb,
    input  logic             grp_sel,
    output logic [GRP-1:0]   neg,
    output logic [GRP-1:0]   flip
);

    localparam int NCH = 2 * GRP;

    typedef struct packed {
        logic [NCH-1:0] last;
        logic [GRP-1:0] neg;
        logic [GRP-1:0] flip;
    } sgn_st_t;

    sgn_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flip = '0;
        if (sample_vld) begin
            for (int i = 0; i < GRP; i++) begin
                st_d.neg[i]  = msb[grp_sel ? GRP + i : i];
                st_d.flip[i] = msb[grp_sel ? GRP + i : i] ^ st_q.last[grp_sel ? GRP + i : i];
            end
            st_d.last = msb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign neg  = st_q.neg;
    assign flip = st_q.flip;

endmodule

// File: rtl/eacc_top.sv
module eacc_top
    import eacc_pkg::*;
#(
    parameter int GRP = 3,
    parameter int PW  = 24,
    parameter int EW  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [31:0]                 cfg_wdata,
    input  logic                        smp_valid,
    input  logic [2*GRP*PW-1:0]         p_act,
    input  logic [2*GRP*PW-1:0]         p_rea,
    input  logic                        zx_strobe,
    input  logic                        rd_en,
    input  logic [$clog2(2*GRP):0]      rd_addr,
    output logic [EW-1:0]               rd_data,
    output logic [GRP-1:0]              act_neg,
    output logic [GRP-1:0]              act_flip,
    output logic [GRP-1:0]              rea_neg,
    output logic [GRP-1:0]              rea_flip,
    output logic                        lc_done_act,
    output logic                        lc_done_rea,
    output logic [2*GRP-1:0]            ovf_act,
    output logic [2*GRP-1:0]            ovf_rea
);

    localparam int NCH = 2 * GRP;
    localparam int CHW = $clog2(NCH);
    localparam int AW  = CHW + 1;

    typedef struct packed {
        eacc_cfg_t     cfg;
        logic [EW-1:0] rd_data;
        logic          done_act;
        logic          done_rea;
    } top_st_t;

    top_st_t        st_d, st_q;
    eacc_kind_e     rd_kind;
    logic [CHW-1:0] rd_ch;
    logic           rd_hit;
    logic           win_end;
    logic [EW-1:0]  act_val [NCH];
    logic [EW-1:0]  rea_val [NCH];
    logic [NCH-1:0] clr_act, clr_rea;
    logic [NCH-1:0] act_msb, rea_msb;
    logic           unused_cfg;

    assign rd_kind    = eacc_kind_e'(rd_addr[AW-1]);
    assign rd_ch      = rd_addr[CHW-1:0];
    assign rd_hit     = rd_en && (int'(rd_ch) < NCH);
    assign unused_cfg = ^{st_q.cfg.spare, st_q.cfg.act_mode, st_q.cfg.rea_mode};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign clr_act[c] = rd_hit && (rd_kind == KIND_ACT) && (rd_ch == CHW'(c))
                            && st_q.cfg.rd_clr && !st_q.cfg.lc_act;
        assign clr_rea[c] = rd_hit && (rd_kind == KIND_REA) && (rd_ch == CHW'(c))
                            && st_q.cfg.rd_clr && !st_q.cfg.lc_rea;
        assign act_msb[c] = p_act[c*PW + PW - 1];
        assign rea_msb[c] = p_rea[c*PW + PW - 1];

        eacc_lane #(.EW(EW), .PW(PW)) i_act (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_vld (smp_valid),
            .sample     (p_act[c*PW +: PW]),
            .lc_mode    (st_q.cfg.lc_act),
            .win_end    (win_end),
            .rd_clear   (clr_act[c]),
            .rd_val     (act_val[c]),
            .ovf        (ovf_act[c])
        );

        eacc_lane #(.EW(EW), .PW(PW)) i_rea (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_vld (smp_valid),
            .sample     (p_rea[c*PW +: PW]),
            .lc_mode    (st_q.cfg.lc_rea),
            .win_end    (win_end),
            .rd_clear   (clr_rea[c]),
            .rd_val     (rea_val[c]),
            .ovf        (ovf_rea[c])
        );
    end

    eacc_zx_window #(.CW(LC_CNT_W)) i_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (st_q.cfg.zx_sel && (st_q.cfg.lc_act || st_q.cfg.lc_rea)),
        .zx       (zx_strobe),
        .target   (st_q.cfg.lc_cycles),
        .win_end  (win_end)
    );

    eacc_sign_mon #(.GRP(GRP)) i_sgn_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (smp_valid),
        .msb        (act_msb),
        .grp_sel    (st_q.cfg.act_grp),
        .neg        (act_neg),
        .flip       (act_flip)
    );

    eacc_sign_mon #(.GRP(GRP)) i_sgn_rea (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (smp_valid),
        .msb        (rea_msb),
        .grp_sel    (st_q.cfg.rea_grp),
        .neg        (rea_neg),
        .flip       (rea_flip)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = eacc_cfg_t'(cfg_wdata);
        st_d.rd_data = '0;
        if (rd_hit) begin
            for (int c = 0; c < NCH; c++) begin
                if (rd_ch == CHW'(c)) begin
                    st_d.rd_data = (rd_kind == KIND_REA) ? rea_val[c] : act_val[c];
                end
            end
        end
        st_d.done_act = win_end && st_q.cfg.lc_act;
        st_d.done_rea = win_end && st_q.cfg.lc_rea;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg      <= eacc_cfg_t'(CFG_RESET);
            st_q.rd_data  <= '0;
            st_q.done_act <= 1'b0;
            st_q.done_rea <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.rd_data;
    assign lc_done_act = st_q.done_act;
    assign lc_done_rea = st_q.done_rea;

endmodule

// File: rtl/eacc_checker.sv
module eacc_checker #(
    parameter int GRP = 3,
    parameter int EW  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             zx_strobe,
    input logic             rd_en,
    input logic [EW-1:0]    rd_data,
    input logic [GRP-1:0]   act_neg,
    input logic [GRP-1:0]   act_flip,
    input logic [GRP-1:0]   rea_neg,
    input logic [GRP-1:0]   rea_flip,
    input logic             lc_done_act,
    input logic             lc_done_rea,
    input logic [2*GRP-1:0] ovf_act,
    input logic [2*GRP-1:0] ovf_rea
);

    assert_rd_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rd_data == '0));

    assert_done_after_zx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_done_act || lc_done_rea) |-> $past(zx_strobe));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(ovf_act) & ~ovf_act) | ($past(ovf_rea) & ~ovf_rea)) == '0));

    assert_sign_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid) |-> ($stable(act_neg) && $stable(rea_neg)));

    assert_flip_on_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_flip != '0) || (rea_flip != '0)) |-> $past(smp_valid));

endmodule

bind eacc_top eacc_checker #(.GRP(GRP), .EW(EW)) i_eacc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .zx_strobe   (zx_strobe),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .act_neg     (act_neg),
    .act_flip    (act_flip),
    .rea_neg     (rea_neg),
    .rea_flip    (rea_flip),
    .lc_done_act (lc_done_act),
    .lc_done_rea (lc_done_rea),
    .ovf_act     (ovf_act),
    .ovf_rea     (ovf_rea)
);

// File: tb/test_eacc_top.sv
module test_eacc_top;

    localparam int GRP = 3;
    localparam int PW  = 12;
    localparam int EW  = 16;
    localparam int NCH = 2 * GRP;
    localparam int CHW = $clog2(NCH);
    localparam int AW  = CHW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic              smp_valid = 1'b0;
    logic [NCH*PW-1:0] p_act = '0;
    logic [NCH*PW-1:0] p_rea = '0;
    logic              zx_strobe = 1'b0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic [EW-1:0]     rd_data;
    logic [GRP-1:0]    act_neg, act_flip, rea_neg, rea_flip;
    logic              lc_done_act, lc_done_rea;
    logic [NCH-1:0]    ovf_act, ovf_rea;

    int tests = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    bit done_flag = 1'b0;

    eacc_top #(.GRP(GRP), .PW(PW), .EW(EW)) i_eacc_top (
        .clk, .rst_n, .cfg_we, .cfg_wdata, .smp_valid, .p_act, .p_rea,
        .zx_strobe, .rd_en, .rd_addr, .rd_data, .act_neg, .act_flip,
        .rea_neg, .rea_flip, .lc_done_act, .lc_done_rea, .ovf_act, .ovf_rea
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    longint         m_acc  [2][NCH];
    longint         m_hold [2][NCH];
    bit             m_ovf  [2][NCH];
    bit             m_last [2][NCH];
    logic [GRP-1:0] m_neg  [2];
    logic [GRP-1:0] m_flip [2];
    bit             m_done [2];
    int             m_cnt;
    logic [31:0]    m_cfg;
    longint         m_rd;

    function automatic longint wrap_e(longint v);
        longint m;
        m = v & ((longint'(1) << EW) - 1);
        if (m >= (longint'(1) << (EW - 1))) m = m - (longint'(1) << EW);
        return m;
    endfunction

    function automatic longint samp(int k, int c);
        if (k == 0) return longint'($signed(p_act[c*PW +: PW]));
        return longint'($signed(p_rea[c*PW +: PW]));
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < NCH; c++) begin
                m_acc[k][c] = 0; m_hold[k][c] = 0; m_ovf[k][c] = 0; m_last[k][c] = 0;
            end
            m_neg[k] = '0; m_flip[k] = '0; m_done[k] = 0;
        end
        m_cnt = 0; m_cfg = 32'h8; m_rd = 0;
    endtask

    task automatic model_step();
        bit     lc [2];
        bit     grp [2];
        int     krd, ch, lim;
        bit     ok, en, we, clr, nb;
        longint add, sum;
        lc[0] = m_cfg[0]; lc[1] = m_cfg[1]; grp[0] = m_cfg[4]; grp[1] = m_cfg[5];
        krd = int'(rd_addr[AW-1]);
        ch  = int'(rd_addr[CHW-1:0]);
        ok  = rd_en && (ch < NCH);
        m_rd = ok ? (lc[krd] ? m_hold[krd][ch] : m_acc[krd][ch]) : 0;
        en  = m_cfg[2] && (lc[0] || lc[1]);
        lim = (m_cfg[31:16] == 0) ? 1 : int'(m_cfg[31:16]);
        we  = en && zx_strobe && (m_cnt + 1 >= lim);
        if (!en) m_cnt = 0;
        else if (zx_strobe) m_cnt = we ? 0 : m_cnt + 1;
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < NCH; c++) begin
                add = smp_valid ? samp(k, c) : 0;
                sum = m_acc[k][c] + add;
                clr = ok && (krd == k) && (ch == c) && m_cfg[3] && !lc[k];
                if (smp_valid && !clr &&
                    (sum > (longint'(1) << (EW-1)) - 1 || sum < -(longint'(1) << (EW-1))))
                    m_ovf[k][c] = 1;
                if (lc[k] && we) begin
                    m_hold[k][c] = wrap_e(sum);
                    m_acc[k][c]  = 0;
                end else if (clr) begin
                    m_acc[k][c] = add;
                end else begin
                    m_acc[k][c] = wrap_e(sum);
                end
            end
            m_flip[k] = '0;
            if (smp_valid) begin
                for (int i = 0; i < GRP; i++) begin
                    nb = samp(k, (grp[k] ? GRP : 0) + i) < 0;
                    m_flip[k][i] = nb != m_last[k][(grp[k] ? GRP : 0) + i];
                    m_neg[k][i]  = nb;
                end
                for (int c = 0; c < NCH; c++) m_last[k][c] = samp(k, c) < 0;
            end
            m_done[k] = we && lc[k];
        end
        if (cfg_we) m_cfg = cfg_wdata;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input longint got, input longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic longint ovf_vec(int k);
        longint v = 0;
        for (int c = 0; c < NCH; c++) if (m_ovf[k][c]) v = v | (longint'(1) << c);
        return v;
    endfunction

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R1 rd_data vs model", longint'($signed(rd_data)), m_rd);
            chk("R9 act_neg vs model", act_neg, m_neg[0]);
            chk("R9 rea_neg vs model", rea_neg, m_neg[1]);
            chk("R10 act_flip vs model", act_flip, m_flip[0]);
            chk("R10 rea_flip vs model", rea_flip, m_flip[1]);
            chk("R7 lc_done_act vs model", lc_done_act, m_done[0]);
            chk("R7 lc_done_rea vs model", lc_done_rea, m_done[1]);
            chk("R8 ovf_act vs model", ovf_act, ovf_vec(0));
            chk("R8 ovf_rea vs model", ovf_rea, ovf_vec(1));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_all(input int a, input int r);
        for (int c = 0; c < NCH; c++) begin
            p_act[c*PW +: PW] = PW'(a + c);
            p_rea[c*PW +: PW] = PW'(r - c);
        end
    endtask

    task automatic sample(input int a, input int r);
        set_all(a, r);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_wdata = w;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic zx();
        zx_strobe = 1'b1;
        @(negedge clk);
        zx_strobe = 1'b0;
    endtask

    task automatic read_chk(input int k, input int ch, input longint exp, input string tag);
        rd_addr = {k[0], ch[CHW-1:0]};
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
        chk(tag, longint'($signed(rd_data)), exp);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n  = 1'b1;
        chk_on = 1'b1;
        // R3 reset state
        chk("R3 rd_data after reset", rd_data, 0);
        chk("R3 ovf_act after reset", ovf_act, 0);
        chk("R3 act_neg after reset", act_neg, 0);
        read_chk(0, 0, 0, "R3 energy zero after reset");

        // R1 / R4 free-running with default read-clear
        sample(100, -50);
        sample(-30, 20);
        read_chk(0, 2, 74, "R1 active ch2 sum");
        read_chk(0, 2, 0, "R4 cleared by read (R3 default on)");
        set_all(5, 0);
        smp_valid = 1'b1;
        rd_addr   = {1'b0, 3'd1};
        rd_en     = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        rd_en     = 1'b0;
        chk("R4 read with concurrent sample returns old", longint'($signed(rd_data)), 72);
        read_chk(0, 1, 6, "R4 concurrent sample kept after clear");
        read_chk(1, 1, -33, "R1 reactive ch1 signed sum");

        // R5 no clear
        write_cfg(32'h0);
        read_chk(0, 0, 75, "R5 first read");
        read_chk(0, 0, 75, "R5 second read unchanged");

        // R2 reserved mode codes
        write_cfg(32'h0000_03C0);
        sample(10, 10);
        read_chk(0, 0, 85, "R2 reserved mode codes accumulate signed");

        // R11 invalid address
        write_cfg(32'h8);
        rd_addr = 4'b0110;
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
        chk("R11 invalid channel reads zero", rd_data, 0);
        read_chk(0, 0, 85, "R11 invalid read cleared nothing");

        // R9 / R10 sign monitoring
        write_cfg(32'h28);
        sample(-3, 4);
        chk("R9 active group0 negative", act_neg, 3'b111);
        chk("R9 reactive group1 sign", rea_neg, 3'b100);
        chk("R10 active flips", act_flip, 3'b111);
        chk("R10 reactive flips", rea_flip, 3'b100);
        sample(-3, 4);
        chk("R10 no flip on same sign", act_flip, 3'b000);
        chk("R9 sign held", act_neg, 3'b111);
        write_cfg(32'h38);
        sample(-3, 4);
        chk("R9 active group1 selected", act_neg, 3'b000);

        // R6 / R7 line-cycle for active energy, window of 3
        read_chk(0, 0, m_acc[0][0], "R4 clear before window");
        write_cfg(32'h0003_000D);
        sample(7, 0);
        zx();
        chk("R7 no done mid-window", lc_done_act, 0);
        sample(7, 0);
        zx();
        zx();
        chk("R7 active done pulse", lc_done_act, 1);
        chk("R7 reactive not in line-cycle", lc_done_rea, 0);
        read_chk(0, 0, 14, "R6 latched value");
        read_chk(0, 0, 14, "R6 read does not clear");
        sample(7, 0);
        zx();
        zx();
        zx();
        read_chk(0, 0, 7, "R7 restart from zero");

        // R7 reactive only, window length 0 behaves as 1
        write_cfg(32'h0000_000E);
        zx();
        chk("R7 reactive done with zero length", lc_done_rea, 1);
        chk("R7 active done stays low", lc_done_act, 0);
        sample(0, 9);
        zx();
        read_chk(1, 0, 9, "R7 reactive latched window");

        // R8 overflow wrap and sticky flag
        write_cfg(32'h0);
        chk("R8 no overflow yet", ovf_act[0], 0);
        for (int n = 0; n < 20; n++) sample(2000, 0);
        chk("R8 overflow flag set", ovf_act[0], 1);
        read_chk(0, 0, -25536, "R8 wrapped value");
        sample(0, 0);
        sample(0, 0);
        chk("R8 overflow flag sticky", ovf_act[0], 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule